// File: doc/BRIEF.md
# Burst-Four Late-Write SRAM Core

This block is a cycle-level, synthesizable model of a synchronous static memory with a shared data path. Each transfer moves four words. Time is counted in beat slots of one internal clock, `clk`. Two slots make one command period. The first slot of each pair is the command slot, and the block marks it with `k_rise`. A command is a load strobe (`ld_n`, active low), a direction bit (`rw`) and a word address. The two lowest address bits choose the word within an aligned group of four where the burst starts. The bits above them choose the group.

Writes use a late-commit scheme. The four beats of a write are gathered into a pending buffer, and each beat carries its own active-low byte-lane enables. The buffer is written into the storage banks on the first data beat of the next write. A read always returns the newest data. It compares the pending group with its own group and takes each enabled pending lane in place of the stored lane. Read words leave on `dq_o` while `dq_oe` is high. This output enable is the direction control for the common bidirectional bus that lies outside the block. Write data enters on `dq_i`.

Top module: `qb4_sram_core`

## Requirements
- R1: Every read and every write moves exactly four words. A read drives four consecutive beat slots, and a write samples `dq_i`/`be_n` on the four clock edges that follow its command edge.
- R2: A command is taken only on an edge whose preceding slot has `k_rise` high while `ld_n` is low. `ld_n` low in a slot where `k_rise` is low has no effect and raises no error. `k_rise` alternates on every slot.
- R3: The direction bit `rw` is sampled with the load strobe. A value of 1 selects a read and 0 selects a write.
- R4: `dq_oe` is high only during the four read-data slots of a burst and is low at all other times.
- R5: `be_n` holds one active-low enable per 9-bit lane. Bit k gates data bits 9k to 9k+8. A lane whose enable is 1 keeps its previous stored content.
- R6: Beat i of a burst addresses word (s + i) mod 4 of the group, where s is the value of address bits [1:0]. The group is given by address bits [ADDR_W-1:2].
- R7: Word i of a read appears on `dq_o`, with `dq_oe` high, in the slot that follows the (3 + i)-th edge after the command edge.
- R8: Write data stays pending until the first data beat of the next write. A read of the pending group returns the enabled pending lanes merged over the stored content, including a read issued directly after the write's last beat.
- R9: A command in a command slot while a burst still occupies the following edges is ignored. `cmd_err` is then high for exactly the one slot that follows that edge.
- R10: After reset, `dq_oe` and `cmd_err` are low, no write is pending, and the first slot after reset release is a command slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock; two slots per command period |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_n | input | 1 | Load strobe, active low, sampled in command slots |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address; bits [1:0] give the burst start |
| be_n | input | LANES | Active-low lane enables for the current write beat |
| dq_i | input | LANES*LANE_W | Write data beat |
| dq_o | output | LANES*LANE_W | Read data beat |
| dq_oe | output | 1 | High while the block drives read data |
| cmd_err | output | 1 | One-slot pulse for a command rejected during a burst |
| k_rise | output | 1 | High in command slots |

## Verification
The bench uses the default parameters: an 8-bit address (64 groups of four words) and four 9-bit lanes. With this size, a reference model of every word fits in the bench. Under these values the vectors can exercise every burst start offset, wrap at each group boundary, enable lane subsets down to the empty mask, and issue reads directly after a write whose data is still pending. This is enough to observe both the bypass merge and the commit path. A directed command placed inside a burst and a strobe placed in an off slot test the rejection paths.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
    localparam int BURST    = 4;
    localparam int BEAT_W   = 2;
    localparam int RD_PIPE  = 6;
    localparam int SNAP_TAP = 1;
    localparam int OUT_TAP  = 2;

    typedef enum logic [0:0] {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } op_e;
endpackage

// File: rtl/qb4_seq.sv
module qb4_seq
    import qb4_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_n,
    input  logic                 rw,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 k_rise,
    output logic                 cmd_err,
    output logic                 wr_beat,
    output logic                 wr_first,
    output logic [BEAT_W-1:0]    wr_word,
    output logic [ADDR_W-3:0]    grp,
    output logic [BEAT_W-1:0]    start,
    output logic                 rd_snap,
    output logic                 out_vld,
    output logic [BEAT_W-1:0]    out_idx
);
    localparam int GROUP_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic               phase;
        logic [2:0]         left;
        op_e                op;
        logic [GROUP_W-1:0] grp;
        logic [BEAT_W-1:0]  start;
        logic [RD_PIPE-1:0] rd_sr;
        logic               err;
    } seq_t;

    seq_t s_d, s_q;
    logic cmd, busy, accept;

    always_comb begin
        s_d       = s_q;
        s_d.phase = ~s_q.phase;
        k_rise    = ~s_q.phase;
        cmd       = k_rise && !ld_n;
        busy      = s_q.left > 3'd1;
        accept    = cmd && !busy;
        s_d.err   = cmd && busy;
        if (s_q.left != 3'd0) begin
            s_d.left = s_q.left - 3'd1;
        end
        s_d.rd_sr = {s_q.rd_sr[RD_PIPE-2:0], accept && rw};
        if (accept) begin
            s_d.left  = 3'(BURST);
            s_d.op    = rw ? OP_READ : OP_WRITE;
            s_d.grp   = addr[ADDR_W-1:BEAT_W];
            s_d.start = addr[BEAT_W-1:0];
        end

        wr_beat  = (s_q.left != 3'd0) && (s_q.op == OP_WRITE);
        wr_first = s_q.left == 3'(BURST);
        wr_word  = s_q.start + 2'(3'(BURST) - s_q.left);
        grp      = s_q.grp;
        start    = s_q.start;
        cmd_err  = s_q.err;
        rd_snap  = s_q.rd_sr[SNAP_TAP];

        out_vld = 1'b0;
        out_idx = '0;
        for (int i = 0; i < BURST; i++) begin
            if (s_q.rd_sr[OUT_TAP + i]) begin
                out_vld = 1'b1;
                out_idx = 2'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: 1'b0, left: 3'd0, op: OP_WRITE, grp: '0,
                     start: '0, rd_sr: '0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/qb4_wbuf.sv
module qb4_wbuf
    import qb4_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int GROUP_W = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              beat_vld,
    input  logic                              beat_first,
    input  logic [BEAT_W-1:0]                 beat_word,
    input  logic [GROUP_W-1:0]                beat_grp,
    input  logic [LANES*LANE_W-1:0]           beat_data,
    input  logic [LANES-1:0]                  beat_be_n,
    output logic                              pend_vld,
    output logic [GROUP_W-1:0]                pend_grp,
    output logic [BURST-1:0][LANES*LANE_W-1:0] pend_data,
    output logic [BURST-1:0][LANES-1:0]       pend_mask,
    output logic                              commit_en
);
    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic                       vld;
        logic [GROUP_W-1:0]         grp;
        logic [BURST-1:0][DW-1:0]   data;
        logic [BURST-1:0][LANES-1:0] mask;
    } wbuf_t;

    wbuf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (beat_vld) begin
            if (beat_first) begin
                s_d.vld  = 1'b1;
                s_d.grp  = beat_grp;
                s_d.mask = '0;
            end
            for (int l = 0; l < LANES; l++) begin
                if (!beat_be_n[l]) begin
                    s_d.data[beat_word][l*LANE_W +: LANE_W] = beat_data[l*LANE_W +: LANE_W];
                    s_d.mask[beat_word][l] = 1'b1;
                end
            end
        end
        commit_en = beat_vld && beat_first && s_q.vld;
        pend_vld  = s_q.vld;
        pend_grp  = s_q.grp;
        pend_data = s_q.data;
        pend_mask = s_q.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/qb4_banks.sv
module qb4_banks
    import qb4_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int GROUP_W = 6
) (
    input  logic                               clk,
    input  logic                               wr_en,
    input  logic [GROUP_W-1:0]                 wr_grp,
    input  logic [BURST-1:0][LANES*LANE_W-1:0] wr_data,
    input  logic [BURST-1:0][LANES-1:0]        wr_mask,
    input  logic [GROUP_W-1:0]                 rd_grp,
    output logic [BURST-1:0][LANES*LANE_W-1:0] rd_data
);
    localparam int DW     = LANES * LANE_W;
    localparam int GROUPS = 1 << GROUP_W;

    for (genvar b = 0; b < BURST; b++) begin : g_bank
        logic [DW-1:0] mem [GROUPS];

        always_ff @(posedge clk) begin
            if (wr_en) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wr_mask[b][l]) begin
                        mem[wr_grp][l*LANE_W +: LANE_W] <= wr_data[b][l*LANE_W +: LANE_W];
                    end
                end
            end
        end

        assign rd_data[b] = mem[rd_grp];
    end
endmodule

// File: rtl/qb4_sram_core.sv
module qb4_sram_core
    import qb4_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_n,
    input  logic                    rw,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        be_n,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe,
    output logic                    cmd_err,
    output logic                    k_rise
);
    localparam int DW      = LANES * LANE_W;
    localparam int GROUP_W = ADDR_W - BEAT_W;

    logic                         wr_beat, wr_first, rd_snap, out_vld;
    logic [BEAT_W-1:0]            wr_word, start, out_idx;
    logic [GROUP_W-1:0]           grp, pend_grp;
    logic                         pend_vld, commit_en;
    logic [BURST-1:0][DW-1:0]     pend_data, arr_data, mrg;
    logic [BURST-1:0][LANES-1:0]  pend_mask;

    qb4_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_n     (ld_n),
        .rw       (rw),
        .addr     (addr),
        .k_rise   (k_rise),
        .cmd_err  (cmd_err),
        .wr_beat  (wr_beat),
        .wr_first (wr_first),
        .wr_word  (wr_word),
        .grp      (grp),
        .start    (start),
        .rd_snap  (rd_snap),
        .out_vld  (out_vld),
        .out_idx  (out_idx)
    );

    qb4_wbuf #(.LANES(LANES), .LANE_W(LANE_W), .GROUP_W(GROUP_W)) u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_vld   (wr_beat),
        .beat_first (wr_first),
        .beat_word  (wr_word),
        .beat_grp   (grp),
        .beat_data  (dq_i),
        .beat_be_n  (be_n),
        .pend_vld   (pend_vld),
        .pend_grp   (pend_grp),
        .pend_data  (pend_data),
        .pend_mask  (pend_mask),
        .commit_en  (commit_en)
    );

    qb4_banks #(.LANES(LANES), .LANE_W(LANE_W), .GROUP_W(GROUP_W)) u_banks (
        .clk     (clk),
        .wr_en   (commit_en),
        .wr_grp  (pend_grp),
        .wr_data (pend_data),
        .wr_mask (pend_mask),
        .rd_grp  (grp),
        .rd_data (arr_data)
    );

    typedef struct packed {
        logic [BURST-1:0][DW-1:0] snap;
        logic [DW-1:0]            dout;
        logic                     oe;
    } out_t;

    out_t s_d, s_q;
    logic hit;

    always_comb begin
        hit = pend_vld && (pend_grp == grp);
        for (int w = 0; w < BURST; w++) begin
            for (int l = 0; l < LANES; l++) begin
                mrg[w][l*LANE_W +: LANE_W] = (hit && pend_mask[w][l])
                    ? pend_data[w][l*LANE_W +: LANE_W]
                    : arr_data[w][l*LANE_W +: LANE_W];
            end
        end

        s_d = s_q;
        if (rd_snap) begin
            for (int i = 0; i < BURST; i++) begin
                s_d.snap[i] = mrg[start + 2'(i)];
            end
        end
        s_d.oe   = out_vld;
        s_d.dout = out_vld ? s_q.snap[out_idx] : '0;

        dq_o  = s_q.dout;
        dq_oe = s_q.oe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/qb4_sram_chk.sv
module qb4_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic ld_n,
    input logic rw,
    input logic k_rise,
    input logic dq_oe,
    input logic cmd_err
);
    AST_K_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        k_rise |=> !k_rise); // R2

    AST_K_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        !k_rise |=> k_rise); // R2

    AST_OE_FOUR_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> dq_oe ##1 dq_oe ##1 dq_oe ##1 dq_oe); // R4

    AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> $past(k_rise && !ld_n && rw, 4)); // R7

    AST_ERR_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(k_rise && !ld_n)); // R9

    AST_ERR_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> !cmd_err); // R9
endmodule

bind qb4_sram_core qb4_sram_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_n    (ld_n),
    .rw      (rw),
    .k_rise  (k_rise),
    .dq_oe   (dq_oe),
    .cmd_err (cmd_err)
);

// File: tb/qb4_sram_core_tb.sv
`timescale 1ns/1ps
module qb4_sram_core_tb;
    localparam int AW = 8;
    localparam int DW = 36;
    localparam int NV = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_n = 1'b1;
    logic          rw = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [3:0]    be_n = 4'hF;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe, cmd_err, k_rise;

    int checks = 0;
    int fails = 0;
    logic [DW-1:0] model [256];

    always #5 clk = ~clk;

    qb4_sram_core u_dut (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .be_n(be_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .cmd_err(cmd_err), .k_rise(k_rise)
    );

    // {is_write, addr, seed, be_n}
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 8'h10, 8'h11, 4'b0000},
        {1'b0, 8'h10, 8'h00, 4'b0000},
        {1'b0, 8'h12, 8'h00, 4'b0000},
        {1'b1, 8'h23, 8'h22, 4'b0000},
        {1'b0, 8'h11, 8'h00, 4'b0000},
        {1'b1, 8'h10, 8'h33, 4'b1010},
        {1'b0, 8'h13, 8'h00, 4'b0000},
        {1'b0, 8'h21, 8'h00, 4'b0000},
        {1'b1, 8'h41, 8'h55, 4'b0000},
        {1'b1, 8'h42, 8'h66, 4'b1111},
        {1'b0, 8'h40, 8'h00, 4'b0000},
        {1'b0, 8'h10, 8'h00, 4'b0000},
        {1'b0, 8'h23, 8'h00, 4'b0000}
    };

    function automatic logic [DW-1:0] beat(input logic [7:0] seed, input int i);
        return {seed, 2'(i), 2'(i), seed ^ 8'h5A, 4'hC, seed + 8'(i * 37), 4'(i)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_k();
        while (!k_rise) @(negedge clk);
    endtask

    task automatic issue(input logic is_rd, input logic [AW-1:0] a);
        wait_k();
        ld_n = 1'b0;
        rw   = is_rd;
        addr = a;
        @(posedge clk);
    endtask

    task automatic rd_check(input logic [DW-1:0] exp [4], input logic [AW-1:0] a);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk(dq_oe === 1'b1, $sformatf("R4 oe beat %0d addr %h", i, a),
                DW'(dq_oe), DW'(1));
            chk(dq_o === exp[i], $sformatf("R1/R6/R7/R8 word %0d addr %h", i, a),
                dq_o, exp[i]);
            if (i < 3) @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] seed,
                            input logic [3:0] b);
        issue(1'b0, a);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i == 0) ld_n = 1'b1;
            dq_i = beat(seed, i);
            be_n = b;
            for (int l = 0; l < 4; l++) begin
                if (!b[l]) model[{a[7:2], a[1:0] + 2'(i)}][l*9 +: 9] = beat(seed, i)[l*9 +: 9];
            end
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        logic [DW-1:0] exp [4];
        issue(1'b1, a);
        for (int i = 0; i < 4; i++) exp[i] = model[{a[7:2], a[1:0] + 2'(i)}];
        fork
            rd_check(exp, a);
        join_none
        @(negedge clk);
        ld_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(k_rise === 1'b1, "R10 first slot is command slot", DW'(k_rise), DW'(1));
        chk(dq_oe === 1'b0, "R10 oe low after reset", DW'(dq_oe), DW'(0));
        chk(cmd_err === 1'b0, "R10 err low after reset", DW'(cmd_err), DW'(0));

        // R3 R5 R6 R8: vector table
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][20]) do_write(VEC[v][19:12], VEC[v][11:4], VEC[v][3:0]);
            else            do_read(VEC[v][19:12]);
        end
        repeat (8) @(negedge clk);

        // R2: strobe in a non-command slot is ignored
        begin
            bit quiet = 1'b1;
            if (k_rise) @(negedge clk);
            ld_n = 1'b0; rw = 1'b1; addr = 8'h10;
            @(negedge clk);
            ld_n = 1'b1;
            for (int i = 0; i < 8; i++) begin
                if (dq_oe !== 1'b0 || cmd_err !== 1'b0) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R2 off-slot strobe ignored", DW'(quiet), DW'(1));
        end

        // R9: command inside a burst is rejected and flagged
        begin
            logic [DW-1:0] exp [4];
            issue(1'b1, 8'h21);
            for (int i = 0; i < 4; i++) exp[i] = model[{6'h08, 2'd1 + 2'(i)}];
            fork
                rd_check(exp, 8'h21);
            join_none
            @(negedge clk);
            ld_n = 1'b1;
            @(negedge clk);
            chk(k_rise === 1'b1, "R9 intrusion slot is command slot", DW'(k_rise), DW'(1));
            ld_n = 1'b0; rw = 1'b0; addr = 8'h20;
            dq_i = 36'h0DEADBEEF; be_n = 4'b0000;
            @(negedge clk);
            ld_n = 1'b1;
            chk(cmd_err === 1'b1, "R9 error pulse raised", DW'(cmd_err), DW'(1));
            @(negedge clk);
            chk(cmd_err === 1'b0, "R9 error pulse one slot", DW'(cmd_err), DW'(0));
            repeat (4) @(negedge clk);
            chk(dq_oe === 1'b0, "R4 oe low after burst", DW'(dq_oe), DW'(0));
        end
        do_read(8'h20);
        repeat (8) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule